// File: doc/BRIEF.md
# Capture Timer Status Flag Register

This block holds the event flags of a two-channel timer that runs in input-capture mode. Each channel has four capture flags, one for each of its capture inputs, and channel 1 also has an overflow flag. The capture logic and the counter sit outside this block. They deliver single-cycle pulses, and each pulse sets the matching flag. Software reads a channel's status byte over a small register port. It then writes zero to the bits it wants to clear.

A clear is guarded. A write of zero to a flag clears it only when the last read of that channel returned 1 for that bit. The read therefore arms the clear, and the next write to that channel uses up the arming. An event that arrives between the read and the write is not lost. Fixed bits read as constants and ignore writes. The underflow position always reads 0 in this mode. An interrupt request is raised while any enabled flag is set.

Top module: `capstat_regs`

## Requirements
- R1: A read with `bus_ch` = c returns channel c's status byte on `bus_rdata` in the same cycle. Capture flags A, B, C and D are bits 0, 1, 2 and 3, and the overflow flag is bit 5. `bus_rdata` is 0 when no read is requested.
- R2: After reset, channel 0 reads 8'hE0 and channel 1 reads 8'hC0.
- R3: Bits 7 and 6 of both channels, and bit 5 of channel 0, always read 1 and ignore writes. An overflow pulse on channel 0 has no effect.
- R4: Bit 4, the underflow position, always reads 0.
- R5: An event pulse sets its flag, which reads 1 from the next cycle. Capture event k of channel c is `cap_evt[c*4+k]`, and the overflow of channel 1 is `ovf_evt[1]`.
- R6: A write of 0 to a flag bit clears it only if the most recent read of that channel returned 1 for that bit. A write with no such read before it leaves the flag set.
- R7: A flag that was 0 at the read and set before the write survives a write of 0.
- R8: Writing 1 to a flag bit leaves it unchanged. The write still uses up the arming of that channel.
- R9: When an event pulse and a qualified clearing write hit the same flag in the same cycle, the flag stays 1.
- R10: Channel 0 capture flag A is set by `cap_evt[0]` when `capa0_use_pin` is 1, and by `capa0_int_evt` when it is 0. The source that is not selected has no effect.
- R11: `irq` is 1 exactly while some flag is set and its enable is 1. The enable for capture k of channel c is `irq_en[c*5+k]`, and the enable for the overflow flag of channel c is `irq_en[c*5+4]`.
- R12: Arming is kept per channel. A new read of a channel replaces its arming, and a read of the other channel does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_ch | input | 1 | Channel select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| cap_evt | input | 8 | Capture event pulses, channel-major |
| ovf_evt | input | 2 | Counter overflow pulses per channel |
| capa0_int_evt | input | 1 | Internal divided-clock edge pulse for channel 0 capture A |
| capa0_use_pin | input | 1 | Channel 0 capture A source: 1 pin, 0 internal |
| irq_en | input | 10 | Per-flag interrupt enables |
| irq | output | 1 | Interrupt request |

## Verification
A hardware set pulse and a clearing write can reach the same flag in the same cycle. A directed case reads a flag as 1 to arm it, then writes zero to it while pulsing its event in that same cycle, and expects the flag to read 1 afterwards. The random phase mixes sparse event pulses with reads and writes of random channels and data, so the same collision recurs alongside events that fall between a read and its write. Each outcome is judged against a bench model of flags and per-channel arming.

// File: rtl/capstat_pkg.sv
package capstat_pkg;
   localparam int STAT_W   = 8;
   localparam int CAP_N    = 4;
   localparam int BIT_UDF  = 4;
   localparam int BIT_OVF  = 5;
   localparam int FLAGS_CH = CAP_N + 1;
   localparam logic [1:0] RSVD_HI = 2'b11;
endpackage

// File: rtl/capstat_flag_cell.sv
module capstat_flag_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic set_evt,
   input  logic rd_hit,
   input  logic wr_hit,
   input  logic wbit,
   output logic flag,
   output logic armed
);
   logic clr_ok;

   assign clr_ok = wr_hit && armed && !wbit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag <= 1'b0;
      end else if (set_evt) begin
         flag <= 1'b1;
      end else if (clr_ok) begin
         flag <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
      end else if (rd_hit) begin
         armed <= flag;
      end else if (wr_hit) begin
         armed <= 1'b0;
      end
   end
endmodule

// File: rtl/capstat_channel.sv
module capstat_channel
   import capstat_pkg::*;
#(
   parameter int NUM_CAP = CAP_N,
   parameter bit HAS_OVF = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rd_hit,
   input  logic                 wr_hit,
   input  logic [STAT_W-1:0]    wdata,
   input  logic [NUM_CAP-1:0]   cap_set,
   input  logic                 ovf_set,
   output logic [STAT_W-1:0]    image,
   output logic [NUM_CAP:0]     flags_o
);
   logic [NUM_CAP-1:0] cap_flag;
   logic               ovf_flag;

   for (genvar k = 0; k < NUM_CAP; k++) begin : g_cap
      logic arm_unused;
      capstat_flag_cell u_cell (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_evt(cap_set[k]),
         .rd_hit (rd_hit),
         .wr_hit (wr_hit),
         .wbit   (wdata[k]),
         .flag   (cap_flag[k]),
         .armed  (arm_unused)
      );
   end

   if (HAS_OVF) begin : g_ovf
      logic arm_unused;
      capstat_flag_cell u_cell (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_evt(ovf_set),
         .rd_hit (rd_hit),
         .wr_hit (wr_hit),
         .wbit   (wdata[BIT_OVF]),
         .flag   (ovf_flag),
         .armed  (arm_unused)
      );
   end else begin : g_no_ovf
      assign ovf_flag = 1'b0;
   end

   always_comb begin
      image                       = '0;
      image[NUM_CAP-1:0]          = cap_flag;
      image[BIT_UDF]              = 1'b0;
      image[BIT_OVF]              = HAS_OVF ? ovf_flag : 1'b1;
      image[STAT_W-1:STAT_W-2]    = RSVD_HI;
   end

   assign flags_o = {ovf_flag, cap_flag};
endmodule

// File: rtl/capstat_regs.sv
module capstat_regs
   import capstat_pkg::*;
#(
   parameter int NUM_CH   = 2,
   parameter int NUM_CAP  = CAP_N,
   parameter bit CH0_OVF  = 1'b0,
   localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   localparam int FPC     = NUM_CAP + 1,
   localparam int NFLAG   = NUM_CH * FPC
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      bus_rd,
   input  logic                      bus_wr,
   input  logic [CH_W-1:0]           bus_ch,
   input  logic [STAT_W-1:0]         bus_wdata,
   output logic [STAT_W-1:0]         bus_rdata,
   input  logic [NUM_CH*NUM_CAP-1:0] cap_evt,
   input  logic [NUM_CH-1:0]         ovf_evt,
   input  logic                      capa0_int_evt,
   input  logic                      capa0_use_pin,
   input  logic [NFLAG-1:0]          irq_en,
   output logic                      irq
);
   if (NUM_CAP != CAP_N) begin : g_bad_cap
      $error("capstat_regs: NUM_CAP must equal the fixed layout width");
   end
   if (NUM_CH < 1) begin : g_bad_ch
      $error("capstat_regs: NUM_CH must be at least 1");
   end

   logic [STAT_W-1:0] ch_image [NUM_CH];
   logic [NFLAG-1:0]  flags_all;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic               sel;
      logic [NUM_CAP-1:0] cset;
      logic [NUM_CAP:0]   fl;

      assign sel = (bus_ch == CH_W'(c));

      if (c == 0) begin : g_src_sel
         always_comb begin
            cset    = cap_evt[NUM_CAP-1:0];
            cset[0] = capa0_use_pin ? cap_evt[0] : capa0_int_evt;
         end
      end else begin : g_src_fixed
         assign cset = cap_evt[c*NUM_CAP +: NUM_CAP];
      end

      capstat_channel #(
         .NUM_CAP(NUM_CAP),
         .HAS_OVF((c == 0) ? CH0_OVF : 1'b1)
      ) u_chan (
         .clk    (clk),
         .rst_n  (rst_n),
         .rd_hit (bus_rd && sel),
         .wr_hit (bus_wr && sel),
         .wdata  (bus_wdata),
         .cap_set(cset),
         .ovf_set(ovf_evt[c]),
         .image  (ch_image[c]),
         .flags_o(fl)
      );

      assign flags_all[c*FPC +: FPC] = fl;
   end

   always_comb begin
      bus_rdata = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         if (bus_rd && bus_ch == CH_W'(c)) bus_rdata = ch_image[c];
      end
   end

   assign irq = |(flags_all & irq_en);
endmodule

// File: rtl/capstat_chk.sv
module capstat_chk
   import capstat_pkg::*;
#(
   parameter int NUM_CH  = 2,
   parameter int NUM_CAP = CAP_N,
   localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   localparam int FPC    = NUM_CAP + 1,
   localparam int NFLAG  = NUM_CH * FPC
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_rd,
   input logic              bus_wr,
   input logic [CH_W-1:0]   bus_ch,
   input logic [STAT_W-1:0] bus_wdata,
   input logic [STAT_W-1:0] bus_rdata,
   input logic [NFLAG-1:0]  flags_all,
   input logic              irq
);
   AST_RSVD_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd |-> bus_rdata[STAT_W-1:STAT_W-2] == 2'b11); // R3
   AST_CH0_B5_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_ch == '0) |-> bus_rdata[BIT_OVF]); // R3
   AST_UDF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd |-> !bus_rdata[BIT_UDF]); // R4
   AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_all == '0) |-> !irq); // R11

   for (genvar i = 0; i < NFLAG; i++) begin : g_flag
      localparam int CH  = i / FPC;
      localparam int K   = i % FPC;
      localparam int POS = (K < NUM_CAP) ? K : BIT_OVF;
      AST_FALL_NEEDS_WR0: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(flags_all[i]) |->
            $past(bus_wr && bus_ch == CH_W'(CH) && !bus_wdata[POS])); // R6
   end
endmodule

bind capstat_regs capstat_chk #(
   .NUM_CH (NUM_CH),
   .NUM_CAP(NUM_CAP)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_rd   (bus_rd),
   .bus_wr   (bus_wr),
   .bus_ch   (bus_ch),
   .bus_wdata(bus_wdata),
   .bus_rdata(bus_rdata),
   .flags_all(flags_all),
   .irq      (irq)
);

// File: tb/capstat_regs_tb.sv
module capstat_regs_tb;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       bus_rd, bus_wr;
   logic [0:0] bus_ch;
   logic [7:0] bus_wdata, bus_rdata;
   logic [7:0] cap_evt;
   logic [1:0] ovf_evt;
   logic       capa0_int_evt, capa0_use_pin;
   logic [9:0] irq_en;
   logic       irq;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   logic [7:0] m_f   [2];
   logic [7:0] m_arm [2];

   always #10 clk = ~clk;

   capstat_regs u_dut (
      .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_ch(bus_ch), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .cap_evt(cap_evt), .ovf_evt(ovf_evt), .capa0_int_evt(capa0_int_evt),
      .capa0_use_pin(capa0_use_pin), .irq_en(irq_en), .irq(irq)
   );

   function automatic logic [7:0] img(int ch);
      return {2'b11, (ch == 0) ? 1'b1 : m_f[ch][5], 1'b0, m_f[ch][3:0]};
   endfunction

   function automatic logic [7:0] fmask(int ch);
      return (ch == 0) ? 8'h0F : 8'h2F;
   endfunction

   function automatic logic model_irq(logic [9:0] en);
      logic r = 1'b0;
      for (int c = 0; c < 2; c++)
         for (int k = 0; k < 5; k++)
            if (m_f[c][(k < 4) ? k : 5] && en[c*5+k]) r = 1'b1;
      return r;
   endfunction

   task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %02h expected %02h", tag, got, exp);
      end
   endtask

   task automatic step(input logic rd, input logic wr, input int ch,
                       input logic [7:0] wd, input logic [7:0] cap,
                       input logic [1:0] ovf, input logic iev, input logic pin,
                       input int exp, input string tag);
      logic [7:0] set, clr, nf [2], na [2];
      @(negedge clk);
      bus_rd = rd; bus_wr = wr; bus_ch = ch[0]; bus_wdata = wd;
      cap_evt = cap; ovf_evt = ovf; capa0_int_evt = iev; capa0_use_pin = pin;
      #1;
      if (rd) chk({tag, " R1 read image"}, bus_rdata, img(ch));
      else    chk("R1 idle rdata", bus_rdata, 8'h00);
      if (exp >= 0) chk(tag, bus_rdata, exp[7:0]);
      chk("R11 irq", {7'd0, irq}, {7'd0, model_irq(irq_en)});
      for (int c = 0; c < 2; c++) begin
         set = '0;
         for (int k = 0; k < 4; k++) set[k] = cap[c*4+k];
         if (c == 0) set[0] = pin ? cap[0] : iev;
         if (c == 1) set[5] = ovf[1];
         clr = (wr && ch == c) ? (m_arm[c] & ~wd & fmask(c)) : 8'h00;
         nf[c] = (m_f[c] & ~clr) | set;
         if (rd && ch == c)      na[c] = img(c) & fmask(c);
         else if (wr && ch == c) na[c] = 8'h00;
         else                    na[c] = m_arm[c];
      end
      for (int c = 0; c < 2; c++) begin
         m_f[c] = nf[c];
         m_arm[c] = na[c];
      end
      @(posedge clk);
   endtask

   task automatic rd(int ch, int exp, string tag);
      step(1, 0, ch, 8'h00, 8'h00, 2'b00, 0, 1, exp, tag);
   endtask
   task automatic wr(int ch, logic [7:0] wd);
      step(0, 1, ch, wd, 8'h00, 2'b00, 0, 1, -1, "wr");
   endtask
   task automatic ev(logic [7:0] cap, logic [1:0] ovf, logic iev, logic pin);
      step(0, 0, 0, 8'h00, cap, ovf, iev, pin, -1, "ev");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int c = 0; c < 2; c++) begin m_f[c] = '0; m_arm[c] = '0; end
      rst_n = 1'b0; bus_rd = 0; bus_wr = 0; bus_ch = 0; bus_wdata = 0;
      cap_evt = 0; ovf_evt = 0; capa0_int_evt = 0; capa0_use_pin = 1; irq_en = '0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      rd(0, 8'hE0, "R2 ch0 reset");
      rd(1, 8'hC0, "R2 ch1 reset");
      rd(1, 8'hC0, "R4 underflow reads 0");
      // R5: capture B (index 5) and overflow on channel 1
      ev(8'h20, 2'b10, 0, 1);
      wr(1, 8'h00);                       // R6: unarmed write, no clear
      rd(1, 8'hE2, "R6 unarmed write keeps flags");
      wr(1, 8'hFF);                       // R8: writing ones
      rd(1, 8'hE2, "R8 write of ones no effect");
      wr(1, 8'hDF);                       // clears overflow only
      rd(1, 8'hC2, "R6 armed clear of bit5");
      ev(8'h10, 2'b00, 0, 1);             // R7: capture A after the read
      wr(1, 8'h00);
      rd(1, 8'hC1, "R7 late event survives");
      step(0, 1, 1, 8'h00, 8'h10, 2'b00, 0, 1, -1, "R9 collide");
      rd(1, 8'hC1, "R9 set wins over clear");
      ev(8'h80, 2'b00, 0, 1);             // capture D
      rd(1, 8'hC9, "R12 arm");
      rd(0, 8'hE0, "R12 other channel read");
      wr(1, 8'h00);
      rd(1, 8'hC0, "R12 arm kept across other read");
      ev(8'h00, 2'b01, 0, 1);             // R3: overflow on channel 0
      rd(0, 8'hE0, "R3 ch0 overflow ignored");
      wr(0, 8'h00);
      rd(0, 8'hE0, "R3 fixed bits ignore writes");
      ev(8'h00, 2'b00, 1, 1);             // R10: internal edge while pin chosen
      rd(0, 8'hE0, "R10 unselected internal edge");
      ev(8'h00, 2'b00, 1, 0);
      rd(0, 8'hE1, "R10 internal edge selected");
      ev(8'h04, 2'b00, 0, 1);             // R5: channel 0 capture C
      rd(0, 8'hE5, "R5 ch0 capture C");
      @(negedge clk) irq_en = 10'h000; #1 chk("R11 disabled", {7'd0, irq}, 8'h00);
      @(negedge clk) irq_en = 10'h004; #1 chk("R11 enabled C", {7'd0, irq}, 8'h01);

      for (int i = 0; i < 4000; i++) begin
         logic [7:0] cap;
         logic [1:0] ovf;
         int op;
         cap = '0; ovf = '0;
         for (int b = 0; b < 8; b++) cap[b] = ($urandom % 12) == 0;
         for (int b = 0; b < 2; b++) ovf[b] = ($urandom % 12) == 0;
         if (($urandom % 16) == 0) irq_en = 10'($urandom);
         op = $urandom % 4;
         step(op == 1, op >= 2, $urandom % 2,
              ($urandom % 2) ? 8'h00 : 8'($urandom), cap, ovf,
              ($urandom % 8) == 0, ($urandom % 2) == 0, -1, "R6 R9 random");
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule